// File: doc/BRIEF.md
# Cache-Blocked Load Replay Queue

This block parks memory operations that the data cache turned away and feeds them back to issue once the cache says it can take requests again. A refused operation is not flushed. It is held in a parked state until a cache-unblocked pulse arrives. The pulse is global: it wakes every parked entry, whatever its thread. After the pulse, the entries become retry candidates and compete for issue lanes and per-class functional units.

A second, smaller list holds operations whose address translation is still pending. Such an entry becomes eligible once its translation is marked done, or once a squash has killed it. Both lists issue through the same lanes, and both are bound by the same per-class unit counts.

Each operation is carried as a tag made of a sequence number, a thread id and an operation class. A squash names a thread and a sequence number; every younger operation of that thread is affected.

Top module: `replay_queue`

## Requirements
- R1: After reset both lists are empty: `iss_valid` is 0, `active` is 0, and `blk_ready` and `def_ready` are 1.
- R2: A parked entry (stored through the block port and not yet woken) never issues, whatever `fu_avail` holds. Parked entries alone do not raise `active`.
- R3: An `unblock` pulse turns every parked entry of every thread into a retry candidate, and these can issue from the next cycle. An entry pushed in the same cycle as the pulse stays parked.
- R4: Retry candidates issue oldest first, at most ISSUE_W (2) per cycle. Lanes fill from lane 0 upward. Lane n occupies bits [n*SEQ_W +: SEQ_W] of `iss_seq`, and likewise for `iss_tid` and `iss_cls`.
- R5: Within one cycle, the number of issued entries of class c never exceeds `fu_avail[c*FU_W +: FU_W]`. An entry whose class has no free unit waits, and a younger entry of another class may pass it.
- R6: An entry that issued and is then pushed again through the block port is parked again, and it waits for the next `unblock`.
- R7: A deferred entry issues only after `xl_done` names its thread and sequence number, or after a squash has killed it. A killed entry issues with `iss_kill` set. Eligible deferred entries take lanes ahead of retry candidates.
- R8: `active` is 1 in any cycle in which an entry issues, a retry candidate is stored, or a deferred entry is stored.
- R9: The parked/retry store holds DEPTH (8) entries. `blk_ready` is 0 when it is full, and a push made while `blk_ready` is 0 is dropped. The deferred store holds DDEPTH (4) entries, and `def_ready` reports when it is full.
- R10: `sq_valid` with thread T and sequence number S removes every parked or retry entry of thread T whose sequence number is above S. This includes a block push in the same cycle. The same squash kills the matching deferred entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Push of a cache-refused operation |
| blk_ready | output | 1 | Parked/retry store has room |
| blk_seq | input | SEQ_W | Sequence number of refused operation |
| blk_tid | input | TID_W | Thread of refused operation |
| blk_cls | input | CLS_W | Class of refused operation |
| unblock | input | 1 | Cache can accept requests again |
| def_valid | input | 1 | Push of a translation-pending operation |
| def_ready | output | 1 | Deferred store has room |
| def_seq | input | SEQ_W | Sequence number of deferred operation |
| def_tid | input | TID_W | Thread of deferred operation |
| def_cls | input | CLS_W | Class of deferred operation |
| xl_done | input | 1 | Translation finished for the named operation |
| xl_seq | input | SEQ_W | Sequence number for `xl_done` |
| xl_tid | input | TID_W | Thread for `xl_done` |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Entries above this sequence number are squashed |
| fu_avail | input | NCLS*FU_W | Free unit count per class this cycle |
| iss_valid | output | ISSUE_W | Lane carries an issued entry |
| iss_seq | output | ISSUE_W*SEQ_W | Sequence number per lane |
| iss_tid | output | ISSUE_W*TID_W | Thread per lane |
| iss_cls | output | ISSUE_W*CLS_W | Class per lane |
| iss_kill | output | ISSUE_W | Lane carries a killed deferred entry |
| active | output | 1 | Work issued or pending this cycle |

## Verification
Issue and re-refusal can land in the same cycle. The bench provokes this by issuing a retry candidate while pushing the same tag back through the block port. It then checks that the entry is absent from the lanes in the next cycle and returns only after a fresh `unblock` pulse. The bench also coincides `unblock` with a new push and a squash with a new push. In both cases it judges the outcome from the lane contents in the following cycles: which sequence numbers appear, and in which order.

// File: rtl/replay_queue.sv
module replay_queue #(
  parameter int SEQ_W   = 8,
  parameter int TID_W   = 1,
  parameter int CLS_W   = 2,
  parameter int FU_W    = 2,
  parameter int DEPTH   = 8,
  parameter int DDEPTH  = 4,
  parameter int ISSUE_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       blk_valid,
  output logic                       blk_ready,
  input  logic [SEQ_W-1:0]           blk_seq,
  input  logic [TID_W-1:0]           blk_tid,
  input  logic [CLS_W-1:0]           blk_cls,
  input  logic                       unblock,
  input  logic                       def_valid,
  output logic                       def_ready,
  input  logic [SEQ_W-1:0]           def_seq,
  input  logic [TID_W-1:0]           def_tid,
  input  logic [CLS_W-1:0]           def_cls,
  input  logic                       xl_done,
  input  logic [SEQ_W-1:0]           xl_seq,
  input  logic [TID_W-1:0]           xl_tid,
  input  logic                       sq_valid,
  input  logic [TID_W-1:0]           sq_tid,
  input  logic [SEQ_W-1:0]           sq_seq,
  input  logic [(1<<CLS_W)*FU_W-1:0] fu_avail,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*SEQ_W-1:0]   iss_seq,
  output logic [ISSUE_W*TID_W-1:0]   iss_tid,
  output logic [ISSUE_W*CLS_W-1:0]   iss_cls,
  output logic [ISSUE_W-1:0]         iss_kill,
  output logic                       active
);
  localparam int NCLS = 1 << CLS_W;
  localparam logic [FU_W-1:0] FU_ONE = 1;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [TID_W-1:0] tid;
    logic [CLS_W-1:0] cls;
  } tag_t;

  tag_t              q_tag [DEPTH];
  logic [DEPTH-1:0]  q_v, q_rt;
  tag_t              d_tag [DDEPTH];
  logic [DDEPTH-1:0] d_v, d_ok, d_kill;

  tag_t              nq_tag [DEPTH];
  logic [DEPTH-1:0]  nq_v, nq_rt, q_take;
  tag_t              nd_tag [DDEPTH];
  logic [DDEPTH-1:0] nd_v, nd_ok, nd_kill, d_take;
  logic [FU_W-1:0]   fu_left [NCLS];

  tag_t blk_tag, def_tag;
  assign blk_tag = '{seq: blk_seq, tid: blk_tid, cls: blk_cls};
  assign def_tag = '{seq: def_seq, tid: def_tid, cls: def_cls};

  assign blk_ready = !q_v[DEPTH-1];
  assign def_ready = !d_v[DDEPTH-1];
  assign active    = (|iss_valid) || (|(q_v & q_rt)) || (|d_v);

  function automatic logic squashed(input tag_t t);
    return sq_valid && t.tid == sq_tid && t.seq > sq_seq;
  endfunction

  always_comb begin
    int unsigned lanes;
    lanes     = 0;
    q_take    = '0;
    d_take    = '0;
    iss_valid = '0;
    iss_seq   = '0;
    iss_tid   = '0;
    iss_cls   = '0;
    iss_kill  = '0;
    for (int c = 0; c < NCLS; c++) fu_left[c] = fu_avail[c*FU_W +: FU_W];
    for (int j = 0; j < DDEPTH; j++) begin
      if (d_v[j] && (d_ok[j] || d_kill[j]) && lanes < ISSUE_W && fu_left[d_tag[j].cls] != '0) begin
        fu_left[d_tag[j].cls] = fu_left[d_tag[j].cls] - FU_ONE;
        d_take[j] = 1'b1;
        iss_valid[lanes] = 1'b1;
        iss_kill[lanes]  = d_kill[j];
        iss_seq[lanes*SEQ_W +: SEQ_W] = d_tag[j].seq;
        iss_tid[lanes*TID_W +: TID_W] = d_tag[j].tid;
        iss_cls[lanes*CLS_W +: CLS_W] = d_tag[j].cls;
        lanes = lanes + 1;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (q_v[i] && q_rt[i] && lanes < ISSUE_W && fu_left[q_tag[i].cls] != '0) begin
        fu_left[q_tag[i].cls] = fu_left[q_tag[i].cls] - FU_ONE;
        q_take[i] = 1'b1;
        iss_valid[lanes] = 1'b1;
        iss_seq[lanes*SEQ_W +: SEQ_W] = q_tag[i].seq;
        iss_tid[lanes*TID_W +: TID_W] = q_tag[i].tid;
        iss_cls[lanes*CLS_W +: CLS_W] = q_tag[i].cls;
        lanes = lanes + 1;
      end
    end
  end

  always_comb begin
    int k;
    k     = 0;
    nq_v  = '0;
    nq_rt = '0;
    for (int i = 0; i < DEPTH; i++) nq_tag[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_v[i] && !q_take[i] && !squashed(q_tag[i])) begin
        nq_tag[k] = q_tag[i];
        nq_v[k]   = 1'b1;
        nq_rt[k]  = q_rt[i] | unblock;
        k = k + 1;
      end
    end
    if (blk_valid && blk_ready && !squashed(blk_tag) && k < DEPTH) begin
      nq_tag[k] = blk_tag;
      nq_v[k]   = 1'b1;
    end
  end

  always_comb begin
    int k;
    k       = 0;
    nd_v    = '0;
    nd_ok   = '0;
    nd_kill = '0;
    for (int j = 0; j < DDEPTH; j++) nd_tag[j] = '0;
    for (int j = 0; j < DDEPTH; j++) begin
      if (d_v[j] && !d_take[j]) begin
        nd_tag[k]  = d_tag[j];
        nd_v[k]    = 1'b1;
        nd_ok[k]   = d_ok[j] | (xl_done && xl_tid == d_tag[j].tid && xl_seq == d_tag[j].seq);
        nd_kill[k] = d_kill[j] | squashed(d_tag[j]);
        k = k + 1;
      end
    end
    if (def_valid && def_ready && k < DDEPTH) begin
      nd_tag[k]  = def_tag;
      nd_v[k]    = 1'b1;
      nd_kill[k] = squashed(def_tag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v    <= '0;
      q_rt   <= '0;
      d_v    <= '0;
      d_ok   <= '0;
      d_kill <= '0;
    end else begin
      q_v    <= nq_v;
      q_rt   <= nq_rt;
      d_v    <= nd_v;
      d_ok   <= nd_ok;
      d_kill <= nd_kill;
    end
    q_tag <= nq_tag;
    d_tag <= nd_tag;
  end
endmodule

// File: rtl/replay_queue_chk.sv
module replay_queue_chk #(
  parameter int CLS_W   = 2,
  parameter int FU_W    = 2,
  parameter int ISSUE_W = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       blk_ready,
  input logic                       unblock,
  input logic                       sq_valid,
  input logic [(1<<CLS_W)*FU_W-1:0] fu_avail,
  input logic [ISSUE_W-1:0]         iss_valid,
  input logic [ISSUE_W*CLS_W-1:0]   iss_cls,
  input logic                       active
);
  localparam int NCLS = 1 << CLS_W;

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (iss_valid == '0 && !active && blk_ready));

  a_r8_active_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (|iss_valid) |-> active);

  a_r3_unblock_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (unblock && !blk_ready && !sq_valid) |=> active);

  for (genvar l = 1; l < ISSUE_W; l++) begin : g_lane
    a_r4_lane_packed: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[l] |-> iss_valid[l-1]);
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [ISSUE_W-1:0] hit;
    for (genvar l = 0; l < ISSUE_W; l++) begin : g_hit
      assign hit[l] = iss_valid[l] && iss_cls[l*CLS_W +: CLS_W] == CLS_W'(c);
    end
    a_r5_fu_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= int'(fu_avail[c*FU_W +: FU_W]));
  end
endmodule

bind replay_queue replay_queue_chk #(.CLS_W(CLS_W), .FU_W(FU_W), .ISSUE_W(ISSUE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_ready(blk_ready), .unblock(unblock), .sq_valid(sq_valid),
  .fu_avail(fu_avail), .iss_valid(iss_valid), .iss_cls(iss_cls), .active(active)
);

// File: tb/sim_replay_queue.sv
module sim_replay_queue;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, blk_valid, blk_ready, unblock, def_valid, def_ready, xl_done, sq_valid, active;
  logic [7:0] blk_seq, def_seq, xl_seq, sq_seq, fu_avail;
  logic       blk_tid, def_tid, xl_tid, sq_tid;
  logic [1:0] blk_cls, def_cls, iss_valid, iss_tid, iss_kill;
  logic [15:0] iss_seq;
  logic [3:0]  iss_cls;

  replay_queue u0 (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_seq(blk_seq),
    .blk_tid(blk_tid), .blk_cls(blk_cls), .unblock(unblock), .def_valid(def_valid),
    .def_ready(def_ready), .def_seq(def_seq), .def_tid(def_tid), .def_cls(def_cls),
    .xl_done(xl_done), .xl_seq(xl_seq), .xl_tid(xl_tid), .sq_valid(sq_valid), .sq_tid(sq_tid),
    .sq_seq(sq_seq), .fu_avail(fu_avail), .iss_valid(iss_valid), .iss_seq(iss_seq),
    .iss_tid(iss_tid), .iss_cls(iss_cls), .iss_kill(iss_kill), .active(active)
  );

  typedef struct packed {
    logic [1:0] c0, c1, c2;
    logic [7:0] fu;
    logic [1:0] ev;
    logic [7:0] s0, s1;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{c0: 2'd0, c1: 2'd0, c2: 2'd0, fu: 8'h03, ev: 2'b11, s0: 8'd1, s1: 8'd2},
    '{c0: 2'd0, c1: 2'd0, c2: 2'd1, fu: 8'h05, ev: 2'b11, s0: 8'd1, s1: 8'd3},
    '{c0: 2'd1, c1: 2'd2, c2: 2'd3, fu: 8'h00, ev: 2'b00, s0: 8'd0, s1: 8'd0},
    '{c0: 2'd2, c1: 2'd2, c2: 2'd2, fu: 8'h10, ev: 2'b01, s0: 8'd1, s1: 8'd0},
    '{c0: 2'd3, c1: 2'd1, c2: 2'd1, fu: 8'h08, ev: 2'b11, s0: 8'd2, s1: 8'd3},
    '{c0: 2'd0, c1: 2'd1, c2: 2'd2, fu: 8'h10, ev: 2'b01, s0: 8'd3, s1: 8'd0}
  };

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; blk_valid = 1'b0; unblock = 1'b0; def_valid = 1'b0; xl_done = 1'b0;
    sq_valid = 1'b0; fu_avail = 8'h00; blk_seq = '0; blk_tid = 1'b0; blk_cls = '0;
    def_seq = '0; def_tid = 1'b0; def_cls = '0; xl_seq = '0; xl_tid = 1'b0; sq_seq = '0; sq_tid = 1'b0;
    tick; tick;
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [7:0] s, input logic t, input logic [1:0] c);
    blk_valid = 1'b1; blk_seq = s; blk_tid = t; blk_cls = c;
    tick;
    blk_valid = 1'b0;
  endtask

  task automatic dpush(input logic [7:0] s, input logic t, input logic [1:0] c);
    def_valid = 1'b1; def_seq = s; def_tid = t; def_cls = c;
    tick;
    def_valid = 1'b0;
  endtask

  task automatic wake;
    unblock = 1'b1;
    tick;
    unblock = 1'b0;
  endtask

  task automatic lane(input string req, input int n, input bit v, input int s);
    #1;
    chk_eq(req, $sformatf("lane%0d valid", n), int'(iss_valid[n]), int'(v));
    if (v) chk_eq(req, $sformatf("lane%0d seq", n), int'(iss_seq[n*8 +: 8]), s);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset;
    #1;
    chk_eq("R1", "iss_valid", int'(iss_valid), 0);
    chk_eq("R1", "active", int'(active), 0);
    chk_eq("R1", "blk_ready", int'(blk_ready), 1);
    chk_eq("R1", "def_ready", int'(def_ready), 1);

    // R4 R5 table: three parked entries seq 1..3, woken, then one cycle of issue under fu_avail
    for (int r = 0; r < 6; r++) begin
      do_reset;
      push(8'd1, 1'b0, ROWS[r].c0);
      push(8'd2, 1'b0, ROWS[r].c1);
      push(8'd3, 1'b0, ROWS[r].c2);
      wake;
      fu_avail = ROWS[r].fu;
      #1;
      chk_eq("R5", $sformatf("row%0d valid", r), int'(iss_valid), int'(ROWS[r].ev));
      if (ROWS[r].ev[0]) chk_eq("R4", $sformatf("row%0d lane0", r), int'(iss_seq[7:0]), int'(ROWS[r].s0));
      if (ROWS[r].ev[1]) chk_eq("R4", $sformatf("row%0d lane1", r), int'(iss_seq[15:8]), int'(ROWS[r].s1));
    end

    // R2: parked entry stays put
    do_reset;
    push(8'd5, 1'b0, 2'd0);
    fu_avail = 8'hFF;
    #1;
    chk_eq("R2", "iss_valid parked", int'(iss_valid), 0);
    chk_eq("R2", "active parked", int'(active), 0);
    tick; tick;
    lane("R2", 0, 1'b0, 0);
    fu_avail = 8'h00;

    // R3: wake crosses threads; push alongside the pulse stays parked
    push(8'd6, 1'b1, 2'd0);
    unblock = 1'b1; blk_valid = 1'b1; blk_seq = 8'd7; blk_tid = 1'b0; blk_cls = 2'd0;
    tick;
    unblock = 1'b0; blk_valid = 1'b0;
    fu_avail = 8'h03;
    lane("R3", 0, 1'b1, 5);
    lane("R3", 1, 1'b1, 6);
    chk_eq("R3", "lane1 tid", int'(iss_tid[1]), 1);
    tick;
    lane("R3", 0, 1'b0, 0);
    chk_eq("R3", "active with only parked", int'(active), 0);
    wake;
    lane("R3", 0, 1'b1, 7);
    tick;
    fu_avail = 8'h00;

    // R4 R8: order over two cycles; active with retry but no units
    push(8'd20, 1'b0, 2'd0); push(8'd21, 1'b0, 2'd0);
    push(8'd22, 1'b0, 2'd0); push(8'd23, 1'b0, 2'd0);
    wake;
    #1;
    chk_eq("R8", "active retry idle", int'(active), 1);
    chk_eq("R8", "no issue without units", int'(iss_valid), 0);
    fu_avail = 8'h03;
    lane("R4", 0, 1'b1, 20); lane("R4", 1, 1'b1, 21);
    tick;
    lane("R4", 0, 1'b1, 22); lane("R4", 1, 1'b1, 23);
    tick;
    lane("R4", 0, 1'b0, 0);
    chk_eq("R8", "active drained", int'(active), 0);
    fu_avail = 8'h00;

    // R6: issue and refusal in one cycle
    push(8'd30, 1'b0, 2'd0);
    wake;
    fu_avail = 8'h03;
    lane("R6", 0, 1'b1, 30);
    blk_valid = 1'b1; blk_seq = 8'd30; blk_tid = 1'b0; blk_cls = 2'd0;
    tick;
    blk_valid = 1'b0;
    lane("R6", 0, 1'b0, 0);
    wake;
    lane("R6", 0, 1'b1, 30);
    tick;
    fu_avail = 8'h00;

    // R7: deferred waits for translation, then beats the retry entry
    do_reset;
    dpush(8'd40, 1'b0, 2'd1);
    fu_avail = 8'h0C;
    #1;
    chk_eq("R7", "deferred pending", int'(iss_valid), 0);
    chk_eq("R8", "active deferred", int'(active), 1);
    fu_avail = 8'h00;
    push(8'd41, 1'b0, 2'd1);
    wake;
    xl_done = 1'b1; xl_seq = 8'd40; xl_tid = 1'b0;
    tick;
    xl_done = 1'b0;
    fu_avail = 8'h04;
    lane("R7", 0, 1'b1, 40); lane("R7", 1, 1'b0, 0);
    chk_eq("R7", "lane0 kill", int'(iss_kill[0]), 0);
    tick;
    lane("R7", 0, 1'b1, 41);
    tick;
    fu_avail = 8'h00;
    dpush(8'd50, 1'b1, 2'd2);
    sq_valid = 1'b1; sq_tid = 1'b1; sq_seq = 8'd49;
    tick;
    sq_valid = 1'b0;
    fu_avail = 8'h10;
    lane("R7", 0, 1'b1, 50);
    chk_eq("R7", "killed flag", int'(iss_kill[0]), 1);
    tick;
    #1;
    chk_eq("R7", "active after kill drain", int'(active), 0);
    fu_avail = 8'h00;

    // R9: capacity
    do_reset;
    for (int i = 0; i < 8; i++) push(8'(60 + i), 1'b0, 2'd0);
    #1;
    chk_eq("R9", "blk_ready full", int'(blk_ready), 0);
    push(8'd99, 1'b0, 2'd0);
    wake;
    fu_avail = 8'h03;
    for (int r = 0; r < 4; r++) begin
      lane("R9", 0, 1'b1, 60 + 2*r);
      lane("R9", 1, 1'b1, 61 + 2*r);
      tick;
    end
    lane("R9", 0, 1'b0, 0);
    fu_avail = 8'h00;
    for (int i = 0; i < 4; i++) dpush(8'(70 + i), 1'b0, 2'd0);
    #1;
    chk_eq("R9", "def_ready full", int'(def_ready), 0);

    // R10: squash of thread 0 above 9, with a push in the same cycle
    do_reset;
    push(8'd10, 1'b0, 2'd0); push(8'd11, 1'b1, 2'd0);
    push(8'd12, 1'b0, 2'd0); push(8'd8, 1'b0, 2'd0);
    sq_valid = 1'b1; sq_tid = 1'b0; sq_seq = 8'd9;
    blk_valid = 1'b1; blk_seq = 8'd13; blk_tid = 1'b0; blk_cls = 2'd0;
    tick;
    sq_valid = 1'b0; blk_valid = 1'b0;
    wake;
    fu_avail = 8'h03;
    lane("R10", 0, 1'b1, 11); lane("R10", 1, 1'b1, 8);
    tick;
    lane("R10", 0, 1'b0, 0);
    fu_avail = 8'h00;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule